// File: doc/BRIEF.md
# Platform Status and Control Register Bank

This block is a 32-bit register bank that sits in a 4 KiB window of a development-board address map. Software reads it to learn the platform build identity, memory-controller status, the clock-generator settings, which PCIe ports the build includes and how much RAM is fitted. Two board straps feed it: the timer input frequency in MHz and the RAM size in GiB. The bank places these values into the register images it returns.

Software resets the board through one control register. A word write with the reset bit set produces a single-cycle reset-request pulse. A small state machine sequences this pulse. It has three states: `RS_IDLE` accepts a request, `RS_PULSE` drives the pulse for one cycle, and `RS_HOLDOFF` ignores all requests for a fixed number of cycles. The transitions are: RS_IDLE to RS_PULSE on an accepted request; RS_PULSE to RS_HOLDOFF always, loading the hold-off counter; RS_HOLDOFF to itself while the counter is non-zero, decrementing it; and RS_HOLDOFF to RS_IDLE when the counter reaches zero.

Each request on the bus is answered one cycle later. Only word-sized accesses have any effect. A word access that no register decodes raises a sticky status flag, which stays set until reset.

Top module: `plat_regs`

## Requirements
- R1: While reset is held and immediately after it, `rsp_valid`, `rsp_rdata`, `sys_reset_req` and `unimpl_seen` are all 0.
- R2: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Any access whose size is not 2 returns zero data, causes no reset pulse and does not set `unimpl_seen`.
- R3: The register is selected by address bits [15:0] only. Bits above 15 do not change the result.
- R4: Word reads of offsets 0x00, 0x04 and 0x08 (build identity and change numbers) return 0.
- R5: A word read of offset 0x14 (memory status) returns 0x0000_0005: bit 0 is locked and bit 2 is calibrated.
- R6: A word read of offset 0x30 (clock settings) returns 1 in bits [31:24], 1 in bits [23:16], the `timer_mhz` strap in bits [15:8] and 1 in bits [7:0].
- R7: A word read of offset 0x34 (build options) returns 0x0000_000E: the three PCIe port bits [3:1] are set and bit 0 is clear.
- R8: A word read of offset 0x38 (memory configuration) returns `ram_gib` in bits [3:0], ones in bits [15:4] and zeros above.
- R9: A word write to offset 0x10 with bit 4 set makes `sys_reset_req` high for exactly the one cycle after the write edge. The same write with bit 4 clear does nothing.
- R10: After a pulse, reset requests are ignored during the pulse cycle and the 16 hold-off cycles that follow. The earliest write that can produce the next pulse is the one sampled 18 edges after the first.
- R11: Word writes to offsets 0x00, 0x04, 0x08, 0x14, 0x18, 0x30, 0x34 and 0x38 have no effect. Later reads return the same values, no pulse occurs and `unimpl_seen` stays clear. The read data of every write response is zero.
- R12: A word read of any offset other than 0x00, 0x04, 0x08, 0x14, 0x30, 0x34 or 0x38 returns zero and sets `unimpl_seen`. A word write to any offset other than those listed in R11 or 0x10 also sets it. The flag stays set until reset.
- R13: Every cycle with `req_valid` high is followed by exactly one cycle with `rsp_valid` high. `rsp_valid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (see R2) |
| req_addr | input | ADDR_W | Byte address; low 16 bits decoded |
| req_wdata | input | 32 | Write data |
| timer_mhz | input | 8 | Strap: timer input frequency in MHz |
| ram_gib | input | 4 | Strap: fitted RAM in GiB |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Read data; zero for writes and unhandled accesses |
| sys_reset_req | output | 1 | One-cycle system reset request pulse |
| unimpl_seen | output | 1 | Sticky flag for undecoded word accesses |

## Verification
A reset-request write can reach the bank on the last hold-off cycle, the same cycle in which the sequencer returns to idle. The design must ignore that write. The bench issues a pulse, then sends writes both one edge later and exactly 17 edges later, and requires `sys_reset_req` to stay low after each of them. A write at the 18th edge must then produce a pulse. A second overlap is a response and a pulse in the same cycle: the write that triggers the pulse also returns its zero read data with `rsp_valid` in that cycle, and the bench checks both together.

// File: rtl/plat_pkg.sv
package plat_pkg;
    localparam int DATA_W  = 32;
    localparam int OFS_W   = 16;
    localparam int MHZ_W   = 8;
    localparam int GIB_W   = 4;
    localparam int FIELD_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    // Register offsets within the window
    localparam logic [OFS_W-1:0] OFS_BUILD_ID  = 16'h0000;
    localparam logic [OFS_W-1:0] OFS_CORE_CHG  = 16'h0004;
    localparam logic [OFS_W-1:0] OFS_WRAP_CHG  = 16'h0008;
    localparam logic [OFS_W-1:0] OFS_RESET_CTL = 16'h0010;
    localparam logic [OFS_W-1:0] OFS_MEM_STAT  = 16'h0014;
    localparam logic [OFS_W-1:0] OFS_LINK_STAT = 16'h0018;
    localparam logic [OFS_W-1:0] OFS_CLK_SET   = 16'h0030;
    localparam logic [OFS_W-1:0] OFS_BUILD_OPT = 16'h0034;
    localparam logic [OFS_W-1:0] OFS_MEM_CFG   = 16'h0038;

    localparam int RESET_BIT = 4;

    typedef enum logic [1:0] {
        RS_IDLE    = 2'd0,
        RS_PULSE   = 2'd1,
        RS_HOLDOFF = 2'd2
    } rst_state_e;
endpackage

// File: rtl/plat_decode.sv
module plat_decode
    import plat_pkg::*;
(
    input  logic [OFS_W-1:0]  offset,
    input  logic [MHZ_W-1:0]  timer_mhz,
    input  logic [GIB_W-1:0]  ram_gib,
    output logic              rd_hit,
    output logic              wr_hit,
    output logic              is_reset_ctl,
    output logic [DATA_W-1:0] rd_value
);
    localparam logic [FIELD_W-1:0] UNIT = FIELD_W'(1);

    // Read side: values assembled from constants and straps
    always_comb begin
        rd_hit   = 1'b1;
        rd_value = '0;
        unique case (offset)
            OFS_BUILD_ID, OFS_CORE_CHG, OFS_WRAP_CHG: rd_value = '0;
            OFS_MEM_STAT:  rd_value = DATA_W'(32'h0000_0005);
            OFS_CLK_SET:   rd_value = {UNIT, UNIT, timer_mhz, UNIT};
            OFS_BUILD_OPT: rd_value = DATA_W'(32'h0000_000E);
            OFS_MEM_CFG:   rd_value = {16'h0000, 12'hFFF, ram_gib};
            default: begin
                rd_hit   = 1'b0;
                rd_value = '0;
            end
        endcase
    end

    // Write side: read-only offsets are decoded but store nothing
    always_comb begin
        wr_hit       = 1'b1;
        is_reset_ctl = 1'b0;
        unique case (offset)
            OFS_RESET_CTL: is_reset_ctl = 1'b1;
            OFS_BUILD_ID, OFS_CORE_CHG, OFS_WRAP_CHG, OFS_MEM_STAT,
            OFS_LINK_STAT, OFS_CLK_SET, OFS_BUILD_OPT, OFS_MEM_CFG: wr_hit = 1'b1;
            default: wr_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/plat_rst_seq.sv
module plat_rst_seq
    import plat_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse
);
    localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES - 1);

    rst_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_IDLE: if (trigger) state_d = RS_PULSE;
            RS_PULSE: begin
                state_d = RS_HOLDOFF;
                cnt_d   = CNT_LOAD;
            end
            RS_HOLDOFF: begin
                if (cnt_q == '0) state_d = RS_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            RS_PULSE: pulse = 1'b1;
            default:  pulse = 1'b0;
        endcase
    end

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/plat_regs.sv
module plat_regs
    import plat_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int HOLD_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MHZ_W-1:0]  timer_mhz,
    input  logic [GIB_W-1:0]  ram_gib,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sys_reset_req,
    output logic              unimpl_seen
);
    logic              rd_hit, wr_hit, is_reset_ctl;
    logic [DATA_W-1:0] rd_value;
    logic              word_acc, rd_acc, wr_acc, trigger, miss;

    logic unused_bits;
    assign unused_bits = ^{req_addr[ADDR_W-1:OFS_W], req_wdata[DATA_W-1:RESET_BIT+1],
                           req_wdata[RESET_BIT-1:0]};

    plat_decode u_decode (
        .offset       (req_addr[OFS_W-1:0]),
        .timer_mhz    (timer_mhz),
        .ram_gib      (ram_gib),
        .rd_hit       (rd_hit),
        .wr_hit       (wr_hit),
        .is_reset_ctl (is_reset_ctl),
        .rd_value     (rd_value)
    );

    assign word_acc = req_valid && (req_size == SZ_WORD);
    assign rd_acc   = word_acc && !req_write;
    assign wr_acc   = word_acc && req_write;
    assign trigger  = wr_acc && is_reset_ctl && req_wdata[RESET_BIT];
    assign miss     = (rd_acc && !rd_hit) || (wr_acc && !wr_hit);

    plat_rst_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_rst_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (trigger),
        .pulse   (sys_reset_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            unimpl_seen <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_rdata   <= (rd_acc && rd_hit) ? rd_value : '0;
            unimpl_seen <= unimpl_seen || miss;
        end
    end

    // Checker state: cycles since the last pulse, saturating
    localparam int GAP_MAX = HOLD_CYCLES + 1;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (sys_reset_req) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GAP_W'(GAP_MAX)) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_holdoff_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_reset_req && seen_q) |-> (gap_q == GAP_W'(GAP_MAX)));
    assert_sticky_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl_seen |=> unimpl_seen);
    assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_write_rdata_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));
    assert_nonword_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != SZ_WORD) |=> (rsp_rdata == '0));
endmodule

// File: tb/tb_plat_regs.sv
module tb_plat_regs;
    import plat_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  timer_mhz = 8'h19;
    logic [3:0]  ram_gib = 4'd2;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        sys_reset_req;
    logic        unimpl_seen;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    plat_regs dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .timer_mhz(timer_mhz), .ram_gib(ram_gib), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .sys_reset_req(sys_reset_req), .unimpl_seen(unimpl_seen)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd2, 32'h0000_0000, 32'h0, 32'h0000_0000},  // R4
        '{1'b0, 2'd2, 32'h0000_0004, 32'h0, 32'h0000_0000},  // R4
        '{1'b0, 2'd2, 32'h0000_0008, 32'h0, 32'h0000_0000},  // R4
        '{1'b0, 2'd2, 32'h0000_0014, 32'h0, 32'h0000_0005},  // R5
        '{1'b0, 2'd2, 32'h0000_0030, 32'h0, 32'h0101_1901},  // R6
        '{1'b0, 2'd2, 32'h0000_0034, 32'h0, 32'h0000_000E},  // R7
        '{1'b0, 2'd2, 32'h0000_0038, 32'h0, 32'h0000_FFF2},  // R8
        '{1'b0, 2'd2, 32'hABCD_0014, 32'h0, 32'h0000_0005},  // R3
        '{1'b0, 2'd2, 32'h17FF_0038, 32'h0, 32'h0000_FFF2},  // R3
        '{1'b0, 2'd0, 32'h0000_0030, 32'h0, 32'h0000_0000},  // R2
        '{1'b0, 2'd1, 32'h0000_0014, 32'h0, 32'h0000_0000},  // R2
        '{1'b0, 2'd3, 32'h0000_0038, 32'h0, 32'h0000_0000},  // R2
        '{1'b1, 2'd0, 32'h0000_0010, 32'hFFFF_FFFF, 32'h0},  // R2
        '{1'b1, 2'd3, 32'h0000_0010, 32'h0000_0010, 32'h0},  // R2
        '{1'b1, 2'd2, 32'h0000_0010, 32'hFFFF_FFEF, 32'h0},  // R9 bit 4 clear
        '{1'b1, 2'd2, 32'h0000_0030, 32'h1234_5678, 32'h0},  // R11
        '{1'b1, 2'd2, 32'h0000_0014, 32'h0000_0000, 32'h0},  // R11
        '{1'b1, 2'd2, 32'h0000_0018, 32'hFFFF_FFFF, 32'h0},  // R11
        '{1'b0, 2'd2, 32'h0000_0030, 32'h0, 32'h0101_1901},  // R11 readback
        '{1'b0, 2'd2, 32'h0000_0014, 32'h0, 32'h0000_0005}   // R11 readback
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drives one request for one edge; returns at the negedge after it
    task automatic do_req(input logic w, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check("R1 rdata", rsp_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pulse", {31'h0, sys_reset_req}, 32'h0);
        check("R1 flag", {31'h0, unimpl_seen}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            do_req(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wdata);
            check($sformatf("R13 vec %0d rsp_valid", i), {31'h0, rsp_valid}, 32'h1);
            check($sformatf("R2-R11 vec %0d rdata", i), rsp_rdata, VECS[i].exp);
            check($sformatf("R9 vec %0d no pulse", i), {31'h0, sys_reset_req}, 32'h0);
        end
        check("R11 flag clear after decoded accesses", {31'h0, unimpl_seen}, 32'h0);
        @(negedge clk);
        check("R13 idle rsp_valid", {31'h0, rsp_valid}, 32'h0);

        // R6: strap change is reflected
        timer_mhz = 8'h64;
        do_req(1'b0, 2'd2, 32'h0000_0030, 32'h0);
        check("R6 strap 100MHz", rsp_rdata, 32'h0101_6401);
        ram_gib = 4'd1;
        do_req(1'b0, 2'd2, 32'h0000_0038, 32'h0);
        check("R8 strap 1GiB", rsp_rdata, 32'h0000_FFF1);

        // R9: pulse, together with its write response
        do_req(1'b1, 2'd2, 32'h0000_0010, 32'h0000_0010);
        check("R9 pulse high", {31'h0, sys_reset_req}, 32'h1);
        check("R9 rsp with pulse", {31'h0, rsp_valid}, 32'h1);
        check("R11 write rdata zero", rsp_rdata, 32'h0);
        // R10: request one edge later is ignored
        do_req(1'b1, 2'd2, 32'h0000_0010, 32'h0000_0010);
        check("R9 pulse single cycle", {31'h0, sys_reset_req}, 32'h0);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            check("R10 holdoff no pulse", {31'h0, sys_reset_req}, 32'h0);
        end
        // R10: write at edge 17 lands on the final hold-off cycle
        do_req(1'b1, 2'd2, 32'h0000_0010, 32'h0000_0010);
        check("R10 last holdoff edge ignored", {31'h0, sys_reset_req}, 32'h0);
        do_req(1'b1, 2'd2, 32'h0000_0010, 32'h0000_0010);
        check("R10 edge 18 accepted", {31'h0, sys_reset_req}, 32'h1);
        repeat (20) @(negedge clk);

        // R12: undecoded accesses
        check("R12 flag still clear", {31'h0, unimpl_seen}, 32'h0);
        do_req(1'b0, 2'd2, 32'h0000_001C, 32'h0);
        check("R12 undecoded read zero", rsp_rdata, 32'h0);
        check("R12 flag set by read", {31'h0, unimpl_seen}, 32'h1);
        do_req(1'b0, 2'd2, 32'h0000_0014, 32'h0);
        repeat (3) @(negedge clk);
        check("R12 flag sticky", {31'h0, unimpl_seen}, 32'h1);

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flag cleared by reset", {31'h0, unimpl_seen}, 32'h0);
        do_req(1'b0, 2'd2, 32'h0000_0010, 32'h0);
        check("R12 write-only offset reads zero", rsp_rdata, 32'h0);
        check("R12 flag set by read of 0x10", {31'h0, unimpl_seen}, 32'h1);

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_req(1'b1, 2'd2, 32'h0000_0020, 32'hFFFF_FFFF);
        check("R12 flag set by write", {31'h0, unimpl_seen}, 32'h1);
        check("R12 undecoded write no pulse", {31'h0, sys_reset_req}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule